// File: doc/BRIEF.md
# Dual-Issue Integer/Floating-Point Pairing Stage

This block is the issue stage of an in-order, two-wide pipeline. Each cycle the fetch side offers one 64-bit packet that holds two 32-bit instructions. The upper half is the left slot, which is meant for integer or memory work. The lower half is the right slot, which is meant for floating-point work. The block decodes the class and the register operands of both instructions. In the same cycle it decides whether none, one or both of them leave the stage, and it raises a strobe for each slot that issues.

Two instructions leave together only when the left one is integer or memory and the right one is floating point, and only if neither is blocked. The right instruction never leaves ahead of the left one. When only the left instruction leaves, the right one stays in the stage and is tried alone on the following cycles. The fetch side sees ready only in the cycle in which the last live instruction of the packet issues, and it then advances to the next packet.

A small shift record keeps the destination of every load issued from the left slot. Consumers of that destination are held back for `LOAD_DELAY` cycles. This covers the right instruction of the same packet and both instructions of the following packet. Register identities carry a file bit, so integer register n and floating-point register n are different registers.

Top module: `dual_issue_pair`

## Requirements
- R1: Bits [31:30] of each instruction give its class: 00 integer, 01 memory, 10 floating point, 11 no-op. A packet with an integer or memory instruction on the left and a floating-point instruction on the right issues both slots in one cycle when no hazard applies, and ready is raised in that cycle.
- R2: While the left instruction of a packet is live, has not issued and is blocked, the right instruction does not issue, even if it has no hazard of its own.
- R3: Any other class combination of two live instructions issues the left one alone first and the right one alone in the next cycle.
- R4: A no-op in either slot never blocks the other slot. A packet of two no-ops is accepted with ready high and no issue strobe.
- R5: A right instruction that is held is retried alone each cycle until it issues. The left instruction of that packet is not issued again.
- R6: fetch_ready is high exactly in the cycle in which every live instruction of the packet has issued or is issuing. The following cycle treats the inputs as a new packet.
- R7: A right instruction that reads a register written by the left instruction of the same packet does not issue in the same cycle as that left instruction.
- R8: A load issued from the left slot blocks any instruction that reads its destination for the following LOAD_DELAY cycles (default 1). This applies to the held right instruction and to both slots of the next packet.
- R9: A memory load whose destination is a floating-point register (bit 14 = 1 marks a load, bit 13 = 1 selects the floating-point file) pairs with a floating-point operation in one cycle.
- R10: A register identity is its 5-bit index (dst [29:25], src1 [24:20], src2 [19:15]) together with its file. Integer and floating-point operations use their own file. A memory operation takes its base from integer src1 and its data register from the file chosen by bit 13. The same index in different files is never a hazard.
- R11: After reset no load is recorded, the hold state is clear, and no strobe or ready is raised while no packet is offered.
- R12: A store (memory class with bit 14 = 0) writes no register. It creates neither a same-packet hazard nor a load-use hazard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pkt_valid | input | 1 | A packet is offered; it stays stable until fetch_ready |
| pkt_data | input | 64 | Left instruction in [63:32], right instruction in [31:0] |
| issue_left | output | 1 | Left instruction issues this cycle |
| issue_right | output | 1 | Right instruction issues this cycle |
| fetch_ready | output | 1 | Packet fully issued; fetch may advance |

## Verification
The strobes and ready are combinational from the offered packet and the held state, so each result is due in the same cycle as the packet is offered. A hold or a recorded load changes the decision one clock later, and the load record clears LOAD_DELAY clocks after the load issues. The bench therefore drives each packet just after a falling edge and samples a moment later. It advances exactly one clock for each expected step of a sequence, so a held right instruction or a load-use stall is checked in the precise cycle in which it must clear. A sweep over all sixteen class pairs covers pairing and ordering, and directed packets cover the register hazards.

// File: rtl/dip_pkg.sv
package dip_pkg;

   typedef enum logic [1:0] {
      CL_INT = 2'b00,
      CL_MEM = 2'b01,
      CL_FP  = 2'b10,
      CL_NOP = 2'b11
   } iclass_e;

   localparam int CLASS_W = 2;
   localparam int FLAG_W  = 2;   // load flag and register-file flag

   function automatic logic pair_left_ok(input iclass_e c);
      return (c == CL_INT) || (c == CL_MEM);
   endfunction

endpackage

// File: rtl/dip_slot_decode.sv
module dip_slot_decode
   import dip_pkg::*;
#(
   parameter int INSN_W    = 32,
   parameter int REG_IDX_W = 5
)(
   input  logic [INSN_W-1:0]    insn,
   output iclass_e              cls,
   output logic                 live,
   output logic                 is_load,
   output logic                 wr_en,
   output logic [REG_IDX_W:0]   wr_id,
   output logic [1:0]           rd_en,
   output logic [REG_IDX_W:0]   rd_id0,
   output logic [REG_IDX_W:0]   rd_id1
);

   localparam int FIELD_BITS = CLASS_W + 3*REG_IDX_W + FLAG_W;
   localparam int DST_HI     = INSN_W - CLASS_W - 1;
   localparam int S1_HI      = DST_HI - REG_IDX_W;
   localparam int S2_HI      = S1_HI - REG_IDX_W;
   localparam int LD_BIT     = S2_HI - REG_IDX_W;
   localparam int FILE_BIT   = LD_BIT - 1;

   if (FIELD_BITS > INSN_W) begin : g_bad_fields
      $error("dip_slot_decode: fields need %0d bits, INSN_W=%0d", FIELD_BITS, INSN_W);
   end

   if (FILE_BIT > 0) begin : g_spare
      logic unused_spare;
      assign unused_spare = ^insn[FILE_BIT-1:0];
   end

   logic [REG_IDX_W-1:0] f_dst, f_s1, f_s2;
   logic                 f_ld, f_file;

   assign cls    = iclass_e'(insn[INSN_W-1 -: CLASS_W]);
   assign f_dst  = insn[DST_HI -: REG_IDX_W];
   assign f_s1   = insn[S1_HI  -: REG_IDX_W];
   assign f_s2   = insn[S2_HI  -: REG_IDX_W];
   assign f_ld   = insn[LD_BIT];
   assign f_file = insn[FILE_BIT];

   always_comb begin
      live    = 1'b1;
      is_load = 1'b0;
      wr_en   = 1'b0;
      wr_id   = '0;
      rd_en   = 2'b00;
      rd_id0  = '0;
      rd_id1  = '0;
      unique case (cls)
         CL_INT: begin
            wr_en  = 1'b1;
            wr_id  = {1'b0, f_dst};
            rd_en  = 2'b11;
            rd_id0 = {1'b0, f_s1};
            rd_id1 = {1'b0, f_s2};
         end
         CL_FP: begin
            wr_en  = 1'b1;
            wr_id  = {1'b1, f_dst};
            rd_en  = 2'b11;
            rd_id0 = {1'b1, f_s1};
            rd_id1 = {1'b1, f_s2};
         end
         CL_MEM: begin
            rd_en[0] = 1'b1;
            rd_id0   = {1'b0, f_s1};
            if (f_ld) begin
               is_load = 1'b1;
               wr_en   = 1'b1;
               wr_id   = {f_file, f_dst};
            end else begin
               rd_en[1] = 1'b1;
               rd_id1   = {f_file, f_s2};
            end
         end
         default: begin
            live = 1'b0;
         end
      endcase
   end

   // a store never claims a destination
   always_comb begin
      if (cls == CL_MEM && !f_ld)
         assert (!wr_en) else $error("AST_STORE_NO_DEST"); // R12
   end

endmodule

// File: rtl/dip_load_track.sv
module dip_load_track #(
   parameter int RID_W = 6,
   parameter int DEPTH = 1,
   parameter int NQ    = 4
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      ld_fire,
   input  logic [RID_W-1:0]          ld_id,
   input  logic [NQ-1:0]             q_en,
   input  logic [NQ-1:0][RID_W-1:0]  q_id,
   output logic [NQ-1:0]             q_hit
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("dip_load_track: DEPTH must be at least 1");
   end
   if (NQ < 1) begin : g_bad_nq
      $error("dip_load_track: NQ must be at least 1");
   end

   logic [DEPTH-1:0]            st_v;
   logic [DEPTH-1:0][RID_W-1:0] st_id;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_v  <= '0;
         st_id <= '0;
      end else begin
         st_v[0]  <= ld_fire;
         st_id[0] <= ld_id;
         for (int s = 1; s < DEPTH; s++) begin
            st_v[s]  <= st_v[s-1];
            st_id[s] <= st_id[s-1];
         end
      end
   end

   for (genvar q = 0; q < NQ; q++) begin : g_query
      always_comb begin
         q_hit[q] = 1'b0;
         for (int s = 0; s < DEPTH; s++)
            if (q_en[q] && st_v[s] && (st_id[s] == q_id[q]))
               q_hit[q] = 1'b1;
      end
   end

   // a fresh load is always visible to the next cycle's queries
   AST_RECORD_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ld_fire) && q_en[0] && q_id[0] == $past(ld_id) |-> q_hit[0]); // R8

endmodule

// File: rtl/dip_pair_ctrl.sv
module dip_pair_ctrl
   import dip_pkg::*;
#(
   parameter int RID_W = 6
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pkt_go,
   input  iclass_e          l_cls,
   input  logic             l_live,
   input  logic             l_wr_en,
   input  logic [RID_W-1:0] l_wr_id,
   input  logic             l_haz,
   input  iclass_e          r_cls,
   input  logic             r_live,
   input  logic [1:0]       r_rd_en,
   input  logic [RID_W-1:0] r_rd_id0,
   input  logic [RID_W-1:0] r_rd_id1,
   input  logic             r_haz,
   output logic             issue_l,
   output logic             issue_r,
   output logic             ready
);

   logic left_done;
   logic l_pend, l_gone, pairable, same_raw, r_order_ok;

   assign l_pend     = l_live && !left_done;
   assign issue_l    = pkt_go && l_pend && !l_haz;
   assign l_gone     = !l_pend || issue_l;
   assign pairable   = pair_left_ok(l_cls) && (r_cls == CL_FP);
   assign same_raw   = l_wr_en &&
                       ((r_rd_en[0] && (r_rd_id0 == l_wr_id)) ||
                        (r_rd_en[1] && (r_rd_id1 == l_wr_id)));
   assign r_order_ok = !l_pend || (issue_l && pairable && !same_raw);
   assign issue_r    = pkt_go && r_live && r_order_ok && !r_haz;
   assign ready      = pkt_go && l_gone && (!r_live || issue_r);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       left_done <= 1'b0;
      else if (ready)   left_done <= 1'b0;
      else if (issue_l) left_done <= 1'b1;
   end

   AST_PAIR_CLASSES: assert property (@(posedge clk) disable iff (!rst_n)
      issue_l && issue_r |-> pair_left_ok(l_cls) && r_cls == CL_FP); // R1
   AST_RIGHT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      issue_r |-> !l_live || issue_l || left_done); // R2
   AST_NO_REISSUE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(issue_l) && !$past(ready) |-> !issue_l); // R5
   AST_SAME_RAW: assert property (@(posedge clk) disable iff (!rst_n)
      issue_l && issue_r && l_wr_en |->
         !(r_rd_en[0] && r_rd_id0 == l_wr_id) && !(r_rd_en[1] && r_rd_id1 == l_wr_id)); // R7
   AST_READY_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (!l_live || issue_l || left_done) && (!r_live || issue_r)); // R6
   AST_FRESH_PACKET: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ready) |-> !left_done); // R6
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !pkt_go |-> !issue_l && !issue_r && !ready); // R11

endmodule

// File: rtl/dual_issue_pair.sv
module dual_issue_pair
   import dip_pkg::*;
#(
   parameter int INSN_W     = 32,
   parameter int REG_IDX_W  = 5,
   parameter int LOAD_DELAY = 1,
   parameter bit LEFT_UPPER = 1'b1
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pkt_valid,
   input  logic [2*INSN_W-1:0] pkt_data,
   output logic                issue_left,
   output logic                issue_right,
   output logic                fetch_ready
);

   localparam int RID_W  = REG_IDX_W + 1;
   localparam int NSLOT  = 2;
   localparam int NQUERY = 2 * NSLOT;

   if (INSN_W < 8) begin : g_bad_width
      $error("dual_issue_pair: INSN_W too small");
   end
   if (LOAD_DELAY < 1) begin : g_bad_delay
      $error("dual_issue_pair: LOAD_DELAY must be at least 1");
   end

   // slot 0 = left, slot 1 = right
   logic [NSLOT-1:0][INSN_W-1:0] slot_insn;
   iclass_e                      s_cls     [NSLOT];
   logic [NSLOT-1:0]             s_live, s_load, s_wr_en;
   logic [RID_W-1:0]             s_wr_id   [NSLOT];
   logic [1:0]                   s_rd_en   [NSLOT];
   logic [RID_W-1:0]             s_rd_id0  [NSLOT];
   logic [RID_W-1:0]             s_rd_id1  [NSLOT];

   if (LEFT_UPPER) begin : g_left_upper
      assign slot_insn[0] = pkt_data[2*INSN_W-1:INSN_W];
      assign slot_insn[1] = pkt_data[INSN_W-1:0];
   end else begin : g_left_lower
      assign slot_insn[0] = pkt_data[INSN_W-1:0];
      assign slot_insn[1] = pkt_data[2*INSN_W-1:INSN_W];
   end

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      dip_slot_decode #(
         .INSN_W    (INSN_W),
         .REG_IDX_W (REG_IDX_W)
      ) i_dec (
         .insn    (slot_insn[s]),
         .cls     (s_cls[s]),
         .live    (s_live[s]),
         .is_load (s_load[s]),
         .wr_en   (s_wr_en[s]),
         .wr_id   (s_wr_id[s]),
         .rd_en   (s_rd_en[s]),
         .rd_id0  (s_rd_id0[s]),
         .rd_id1  (s_rd_id1[s])
      );
   end

   logic [NQUERY-1:0]             q_en, q_hit;
   logic [NQUERY-1:0][RID_W-1:0]  q_id;
   logic                          pkt_go, ld_fire;

   for (genvar s = 0; s < NSLOT; s++) begin : g_q
      assign q_en[2*s]   = s_rd_en[s][0];
      assign q_en[2*s+1] = s_rd_en[s][1];
      assign q_id[2*s]   = s_rd_id0[s];
      assign q_id[2*s+1] = s_rd_id1[s];
   end

   assign pkt_go  = pkt_valid && rst_n;
   assign ld_fire = issue_left && s_load[0] && s_wr_en[0];

   dip_load_track #(
      .RID_W (RID_W),
      .DEPTH (LOAD_DELAY),
      .NQ    (NQUERY)
   ) i_track (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_fire (ld_fire),
      .ld_id   (s_wr_id[0]),
      .q_en    (q_en),
      .q_id    (q_id),
      .q_hit   (q_hit)
   );

   dip_pair_ctrl #(
      .RID_W (RID_W)
   ) i_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .pkt_go   (pkt_go),
      .l_cls    (s_cls[0]),
      .l_live   (s_live[0]),
      .l_wr_en  (s_wr_en[0]),
      .l_wr_id  (s_wr_id[0]),
      .l_haz    (|q_hit[1:0]),
      .r_cls    (s_cls[1]),
      .r_live   (s_live[1]),
      .r_rd_en  (s_rd_en[1]),
      .r_rd_id0 (s_rd_id0[1]),
      .r_rd_id1 (s_rd_id1[1]),
      .r_haz    (|q_hit[3:2]),
      .issue_l  (issue_left),
      .issue_r  (issue_right),
      .ready    (fetch_ready)
   );

   logic unused_right;
   assign unused_right = s_load[1] ^ s_wr_en[1] ^ (^s_wr_id[1]);

   // nothing reads a just-loaded register in the cycle after the load
   AST_LOAD_USE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ld_fire) |->
         !(issue_left  && ((s_rd_en[0][0] && s_rd_id0[0] == $past(s_wr_id[0])) ||
                           (s_rd_en[0][1] && s_rd_id1[0] == $past(s_wr_id[0])))) &&
         !(issue_right && ((s_rd_en[1][0] && s_rd_id0[1] == $past(s_wr_id[0])) ||
                           (s_rd_en[1][1] && s_rd_id1[1] == $past(s_wr_id[0]))))); // R8

endmodule

// File: tb/test_dual_issue_pair.sv
module test_dual_issue_pair;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pkt_valid = 1'b0;
   logic [63:0] pkt_data = '0;
   logic        issue_left, issue_right, fetch_ready;

   int n_checks = 0;
   int n_fails  = 0;
   int cyc      = 0;
   bit done     = 1'b0;

   dual_issue_pair i_dual_issue_pair (
      .clk         (clk),
      .rst_n       (rst_n),
      .pkt_valid   (pkt_valid),
      .pkt_data    (pkt_data),
      .issue_left  (issue_left),
      .issue_right (issue_right),
      .fetch_ready (fetch_ready)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      cyc++;
      if (cyc > WATCHDOG && !done) begin
         done = 1'b1;
         n_fails++;
         $display("FAIL watchdog: run hung, got cycle %0d expected below %0d", cyc, WATCHDOG);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

   // class, dst, src1, src2, load flag, fp-file flag
   function automatic logic [31:0] mk(input int c, input int d, input int a,
                                      input int b, input bit ld, input bit fp);
      return {c[1:0], d[4:0], a[4:0], b[4:0], ld, fp, 13'b0};
   endfunction

   task automatic present(input logic [31:0] l, input logic [31:0] r);
      pkt_valid = 1'b1;
      pkt_data  = {l, r};
   endtask

   task automatic expect3(input logic el, input logic er, input logic erd, input string tag);
      #1;
      n_checks++;
      if ({issue_left, issue_right, fetch_ready} !== {el, er, erd}) begin
         n_fails++;
         $display("FAIL %s: got l/r/rdy=%b%b%b expected %b%b%b", tag,
                  issue_left, issue_right, fetch_ready, el, er, erd);
      end
      @(negedge clk);
      #1;
   endtask

   task automatic idle(input int n);
      pkt_valid = 1'b0;
      for (int k = 0; k < n; k++) expect3(1'b0, 1'b0, 1'b0, "R11 idle quiet");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      expect3(1'b0, 1'b0, 1'b0, "R11 during reset");
      rst_n = 1'b1;
      #1;
      idle(1);

      // R11: empty record after reset, distinct files for index 1
      present(mk(0, 1, 5, 6, 0, 0), mk(2, 1, 5, 6, 0, 0));
      expect3(1'b1, 1'b1, 1'b1, "R11/R10 first packet after reset");

      // sweep of all class pairs without register conflicts
      for (int lc = 0; lc < 4; lc++) begin
         for (int rc = 0; rc < 4; rc++) begin
            bit    ll, rl, pr;
            string tg;
            ll = (lc != 3);
            rl = (rc != 3);
            pr = (lc == 0 || lc == 1) && rc == 2;
            tg = $sformatf("R1/R3/R4/R5/R6 sweep lc=%0d rc=%0d", lc, rc);
            present(mk(lc, 10, 1, 2, lc == 1, 0), mk(rc, 11, 3, 4, rc == 1, 0));
            if (!ll && !rl)      expect3(1'b0, 1'b0, 1'b1, tg);
            else if (!ll)        expect3(1'b0, 1'b1, 1'b1, tg);
            else if (!rl)        expect3(1'b1, 1'b0, 1'b1, tg);
            else if (pr)         expect3(1'b1, 1'b1, 1'b1, tg);
            else begin
               expect3(1'b1, 1'b0, 1'b0, tg);
               expect3(1'b0, 1'b1, 1'b1, tg);
            end
            idle(1);
         end
      end

      // R2 and R8: left consumer of a load stalls, ready right waits with it
      present(mk(1, 5, 1, 0, 1, 0), mk(3, 0, 0, 0, 0, 0));
      expect3(1'b1, 1'b0, 1'b1, "R8 integer load issues");
      present(mk(0, 6, 5, 2, 0, 0), mk(2, 15, 1, 2, 0, 0));
      expect3(1'b0, 1'b0, 1'b0, "R2/R8 left stalled, right waits");
      expect3(1'b1, 1'b1, 1'b1, "R2/R8 pair after one stall");
      idle(1);

      // R8: right consumer of the next packet
      present(mk(1, 7, 1, 0, 1, 1), mk(3, 0, 0, 0, 0, 0));
      expect3(1'b1, 1'b0, 1'b1, "R8 fp load issues");
      present(mk(0, 16, 1, 2, 0, 0), mk(2, 17, 2, 7, 0, 0));
      expect3(1'b1, 1'b0, 1'b0, "R8 right blocked by load record");
      expect3(1'b0, 1'b1, 1'b1, "R8/R5 held right issues alone");
      idle(1);

      // R7, R5, R8: same-packet read of a loaded fp register
      present(mk(1, 8, 1, 0, 1, 1), mk(2, 14, 8, 2, 0, 0));
      expect3(1'b1, 1'b0, 1'b0, "R7 same-packet RAW holds right");
      expect3(1'b0, 1'b0, 1'b0, "R8/R5 held right still in load delay");
      expect3(1'b0, 1'b1, 1'b1, "R5 held right issues");
      idle(2);

      // R10: integer load r9 with fp consumer of f9
      present(mk(1, 9, 1, 0, 1, 0), mk(2, 18, 9, 9, 0, 0));
      expect3(1'b1, 1'b1, 1'b1, "R10 different file no hazard");
      idle(2);

      // R9: fp load pairs with fp operation
      present(mk(1, 12, 1, 0, 1, 1), mk(2, 13, 1, 2, 0, 0));
      expect3(1'b1, 1'b1, 1'b1, "R9 fp load paired with fp op");
      idle(2);

      // R12: store has no destination
      present(mk(1, 4, 1, 3, 0, 1), mk(2, 3, 3, 3, 0, 0));
      expect3(1'b1, 1'b1, 1'b1, "R12 store paired with fp op");
      present(mk(0, 5, 4, 4, 0, 0), mk(3, 0, 0, 0, 0, 0));
      expect3(1'b1, 1'b0, 1'b1, "R12 no load-use after store");
      idle(2);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

endmodule